// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh

This block connects a simple processor-side request port to an asynchronous DRAM that takes a multiplexed row/column address and active-low row and column strobes. Each request address is split into a row part (upper bits) and a column part (lower bits). After a row is opened, the row strobe stays low. Later accesses to the same row then need only a new column address and a column strobe pulse. An access to a different row closes the page, waits out a precharge interval and opens the new row.

The controller also issues a CAS-before-RAS refresh at a fixed interval. It never leaves a row open longer than a set limit. A pending refresh is served ahead of new requests: the controller finishes any in-flight access, precharges the open page and then refreshes. The requester holds `req` with its command until `ready` pulses for one cycle. While the controller inserts wait states, `ready` stays low. All timings are parameters counted in clock cycles.

Top module: `page_dram_ctrl`

## Requirements
- R1: The row driven on `dram_addr` when `dram_ras_n` falls is `addr[ROW_W+COL_W-1:COL_W]`, zero-extended. The column driven when `dram_cas_n` falls is `addr[COL_W-1:0]`, zero-extended.
- R2: With no page open, `ready` rises on the (T_RCD + T_CW)-th rising edge after the edge that accepts the request, where T_CW = max(T_CAS, T_ACC).
- R3: An access to the open row (a page hit) causes no `dram_ras_n` transition, and `ready` rises T_CW edges after acceptance.
- R4: An access to a different row (a page miss) raises `dram_ras_n`. `dram_ras_n` stays high at least T_RP cycles before it falls again, and `ready` rises T_RP + T_RCD + T_CW edges after acceptance.
- R5: Read data is taken from `dram_rdata` only after `dram_cas_n` has been low for T_CW >= T_ACC cycles. `rdata` changes only in a cycle where `ready` is high.
- R6: For a write, `dram_we_n` is low only while both strobes are low, and `dram_wdata` equals `wdata` when `dram_cas_n` falls.
- R7: `ready` is a one-cycle pulse. A request held through its `ready` cycle produces exactly one column strobe.
- R8: Every REF_INT cycles a refresh runs. `dram_cas_n` falls one cycle before `dram_ras_n`, and `dram_ras_n` then stays low T_REF cycles. When the controller is idle with no page open, successive refreshes start exactly REF_INT cycles apart.
- R9: `dram_ras_n` never stays low for more than RAS_MAX cycles. An idle open page closes by itself after RAS_MAX - T_CW cycles.
- R10: A pending refresh wins over new requests. It closes an open page with a precharge, so the next access to the same row is a closed-page access with a new row strobe.
- R11: While and after reset, both strobes and `dram_we_n` are high, `ready` and `rdata` are zero, and no page is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Request address, row in upper bits |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, updated with `ready` |
| ready | output | 1 | One-cycle completion pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_wdata | output | DW | Data driven to the DRAM |
| dram_rdata | input | DW | Data returned by the DRAM |

## Verification
Each access's `ready` is due a fixed number of edges after the accepting edge: T_RCD + T_CW with no page open, T_CW on a hit, and T_RP + T_RCD + T_CW on a miss. The bench drives a request on a falling edge and counts rising edges until it sees `ready` at a later falling edge. It compares that count to the requirement's sum plus one, and it reads `rdata` in that same half cycle. Refresh spacing, refresh strobe width and page lifetime are measured by a DRAM model that timestamps strobe edges. The model returns valid read data only once the column strobe has been low for the access time.

// File: rtl/page_dram_pkg.sv
`timescale 1ns/1ps
package page_dram_pkg;

  typedef enum logic [2:0] {
    ST_CLOSED = 3'd0,
    ST_ROWACT = 3'd1,
    ST_COL    = 3'd2,
    ST_OPEN   = 3'd3,
    ST_PRECH  = 3'd4,
    ST_REFCAS = 3'd5,
    ST_REFRAS = 3'd6
  } pdc_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdc_addr_split.sv
`timescale 1ns/1ps
module pdc_addr_split #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int MA_W  = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [ROW_W-1:0]       row,
  output logic [MA_W-1:0]        row_bus,
  output logic [MA_W-1:0]        col_bus
);
  // upper bits select the page, lower bits the word inside it
  assign row     = addr[ROW_W+COL_W-1:COL_W];
  assign row_bus = MA_W'(addr[ROW_W+COL_W-1:COL_W]);
  assign col_bus = MA_W'(addr[COL_W-1:0]);
endmodule

// File: rtl/pdc_refresh_tick.sv
`timescale 1ns/1ps
module pdc_refresh_tick #(
  parameter int REF_INT = 1500,
  parameter int ROW_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CW = (REF_INT > 1) ? $clog2(REF_INT) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pend    <= 1'b0;
      ref_row <= '0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      pend <= (cnt == LAST) | (pend & ~ack);
      if (ack) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/pdc_open_guard.sv
`timescale 1ns/1ps
module pdc_open_guard #(
  parameter int LIMIT = 900
) (
  input  logic clk,
  input  logic rst,
  input  logic open,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (!open)     cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/page_dram_ctrl.sv
`timescale 1ns/1ps
module page_dram_ctrl
  import page_dram_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int DW      = 16,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_ACC   = 3,
  parameter int T_RP    = 2,
  parameter int T_REF   = 4,
  parameter int REF_INT = 1500,
  parameter int RAS_MAX = 1000,
  localparam int AW     = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            ready,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic [MA_W-1:0] dram_addr,
  output logic [DW-1:0]   dram_wdata,
  input  logic [DW-1:0]   dram_rdata
);
  localparam int T_CW  = max2(T_CAS, T_ACC);
  localparam int T_MAX = max2(max2(T_RCD, T_CW), max2(T_RP, T_REF));
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int G_LIM = RAS_MAX - T_CW - 1;

  pdc_state_t state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             done;

  logic [ROW_W-1:0] req_row, open_row;
  logic [MA_W-1:0]  row_bus, col_bus;
  logic             lat_we;
  logic [MA_W-1:0]  lat_col;
  logic [DW-1:0]    lat_wdata;
  logic             src_we;
  logic [MA_W-1:0]  src_col;
  logic [DW-1:0]    src_wdata;

  logic             ref_pend, ref_ack, expired, new_req, row_hit, accept;
  logic [ROW_W-1:0] ref_row;

  pdc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_split (
    .addr(addr), .row(req_row), .row_bus(row_bus), .col_bus(col_bus)
  );

  pdc_refresh_tick #(.REF_INT(REF_INT), .ROW_W(ROW_W)) u_tick (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend), .ref_row(ref_row)
  );

  pdc_open_guard #(.LIMIT(G_LIM)) u_guard (
    .clk(clk), .rst(rst), .open(!dram_ras_n), .expired(expired)
  );

  assign ref_ack = (state == ST_REFCAS);
  assign new_req = req && !ready;
  assign row_hit = (open_row == req_row);

  // a hit taken from the open page uses the live request, every later cycle the latched copy
  assign src_we    = (state == ST_OPEN) ? we      : lat_we;
  assign src_col   = (state == ST_OPEN) ? col_bus : lat_col;
  assign src_wdata = (state == ST_OPEN) ? wdata   : lat_wdata;

  always_comb begin
    state_nx = state;
    cnt_nx   = (cnt != '0) ? cnt - 1'b1 : '0;
    done     = 1'b0;
    unique case (state)
      ST_CLOSED: begin
        if (ref_pend) begin
          state_nx = ST_REFCAS;
        end else if (new_req) begin
          state_nx = ST_ROWACT;
          cnt_nx   = CNT_W'(T_RCD - 1);
        end
      end
      ST_ROWACT: begin
        if (cnt == '0) begin
          state_nx = ST_COL;
          cnt_nx   = CNT_W'(T_CW - 1);
        end
      end
      ST_COL: begin
        if (cnt == '0) begin
          state_nx = ST_OPEN;
          done     = 1'b1;
        end
      end
      ST_OPEN: begin
        if (ref_pend || expired || (new_req && !row_hit)) begin
          state_nx = ST_PRECH;
          cnt_nx   = CNT_W'(T_RP - 1);
        end else if (new_req) begin
          state_nx = ST_COL;
          cnt_nx   = CNT_W'(T_CW - 1);
        end
      end
      ST_PRECH: begin
        if (cnt == '0) begin
          if (ref_pend) begin
            state_nx = ST_REFCAS;
          end else if (new_req) begin
            state_nx = ST_ROWACT;
            cnt_nx   = CNT_W'(T_RCD - 1);
          end else begin
            state_nx = ST_CLOSED;
          end
        end
      end
      ST_REFCAS: begin
        state_nx = ST_REFRAS;
        cnt_nx   = CNT_W'(T_REF - 1);
      end
      ST_REFRAS: begin
        if (cnt == '0) begin
          state_nx = ST_PRECH;
          cnt_nx   = CNT_W'(T_RP - 1);
        end
      end
      default: begin
        state_nx = ST_CLOSED;
      end
    endcase
  end

  assign accept = ((state_nx == ST_ROWACT) && (state != ST_ROWACT)) ||
                  ((state == ST_OPEN) && (state_nx == ST_COL));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLOSED;
      cnt        <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_addr  <= '0;
      dram_wdata <= '0;
      rdata      <= '0;
      ready      <= 1'b0;
      open_row   <= '0;
      lat_we     <= 1'b0;
      lat_col    <= '0;
      lat_wdata  <= '0;
    end else begin
      state      <= state_nx;
      cnt        <= cnt_nx;
      dram_ras_n <= !((state_nx == ST_ROWACT) || (state_nx == ST_COL) ||
                      (state_nx == ST_OPEN)   || (state_nx == ST_REFRAS));
      dram_cas_n <= !((state_nx == ST_COL) || (state_nx == ST_REFCAS) ||
                      (state_nx == ST_REFRAS));
      dram_we_n  <= !((state_nx == ST_COL) && src_we);
      if (state_nx != state) begin
        case (state_nx)
          ST_ROWACT: dram_addr <= row_bus;
          ST_COL: begin
            dram_addr  <= src_col;
            dram_wdata <= src_wdata;
          end
          ST_REFCAS: dram_addr <= MA_W'(ref_row);
          default: ;
        endcase
      end
      if ((state_nx == ST_ROWACT) && (state != ST_ROWACT)) open_row <= req_row;
      if (accept) begin
        lat_we    <= we;
        lat_col   <= col_bus;
        lat_wdata <= wdata;
      end
      ready <= done;
      if (done && !lat_we) rdata <= dram_rdata;
    end
  end
endmodule

// File: rtl/pdc_checker.sv
`timescale 1ns/1ps
module pdc_checker #(
  parameter int T_RP    = 2,
  parameter int RAS_MAX = 1000,
  parameter int DW      = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          ready,
  input logic [DW-1:0] rdata
);
  localparam int LW = $clog2(RAS_MAX + 2);
  localparam int HW = $clog2(T_RP + 2);

  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= '0;
      hi_run <= HW'(T_RP);
    end else begin
      if (!ras_n) lo_run <= (lo_run == LW'(RAS_MAX)) ? lo_run : lo_run + 1'b1;
      else        lo_run <= '0;
      if (ras_n)  hi_run <= (hi_run == HW'(T_RP)) ? hi_run : hi_run + 1'b1;
      else        hi_run <= '0;
    end
  end

  // R9: row strobe low for at most RAS_MAX cycles
  a_r9_ras_limit: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (lo_run < LW'(RAS_MAX)));

  // R4: precharge interval before every row strobe
  a_r4_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_run >= HW'(T_RP)));

  // R7: completion is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R5: read data moves only with ready
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !ready |-> $stable(rdata));

  // R6: write enable only inside a column access
  a_r6_we_in_access: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!cas_n && !ras_n));

  // R8: column strobe leads the row strobe by exactly one cycle in refresh
  a_r8_cbr_lead: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && ras_n) |=> !ras_n);

  a_r8_cbr_order: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
endmodule

bind page_dram_ctrl pdc_checker #(.T_RP(T_RP), .RAS_MAX(RAS_MAX), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .ready(ready), .rdata(rdata)
);

// File: tb/test_page_dram_ctrl.sv
`timescale 1ns/1ps
module test_page_dram_ctrl;
  localparam int ROW_W = 6, COL_W = 5, DW = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_ACC = 3, T_RP = 2, T_REF = 3;
  localparam int REF_INT = 200, RAS_MAX = 150;
  localparam int T_CW = (T_CAS > T_ACC) ? T_CAS : T_ACC;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LAT_CLOSED = T_RCD + T_CW + 1;
  localparam int LAT_HIT    = T_CW + 1;
  localparam int LAT_MISS   = T_RP + T_RCD + T_CW + 1;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, we = 1'b0;
  logic [ROW_W+COL_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, dram_wdata, dram_rdata;
  logic ready, dram_ras_n, dram_cas_n, dram_we_n;
  logic [MA_W-1:0] dram_addr;

  always #2 clk = ~clk;

  page_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_ACC(T_ACC), .T_RP(T_RP), .T_REF(T_REF), .REF_INT(REF_INT), .RAS_MAX(RAS_MAX))
  i_page_dram_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata)
  );

  // DRAM model
  logic [DW-1:0] mem [0:(1<<(ROW_W+COL_W))-1];
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;
  int cyc = 0, cas_cnt = 0, rrun = 0, last_run = 0, max_run = 0;
  int ras_falls = 0, cas_falls = 0, cbr_cnt = 0, cbr_t = 0;

  initial for (int i = 0; i < (1<<(ROW_W+COL_W)); i++) mem[i] = '0;

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    prev_ras <= dram_ras_n;
    prev_cas <= dram_cas_n;
    cas_cnt  <= dram_cas_n ? 0 : cas_cnt + 1;
    rrun     <= dram_ras_n ? 0 : rrun + 1;
    if (!dram_ras_n && rrun + 1 > max_run) max_run <= rrun + 1;
    if (!prev_ras && dram_ras_n) last_run <= rrun;
    if (prev_ras && !dram_ras_n) begin
      if (!dram_cas_n) begin
        cbr_cnt <= cbr_cnt + 1;
        cbr_t   <= cyc;
      end else begin
        ras_falls <= ras_falls + 1;
        row_l     <= dram_addr[ROW_W-1:0];
      end
    end
    if (prev_cas && !dram_cas_n && !dram_ras_n) begin
      cas_falls <= cas_falls + 1;
      col_l     <= dram_addr[COL_W-1:0];
      if (!dram_we_n) mem[{row_l, dram_addr[COL_W-1:0]}] <= dram_wdata;
    end
  end

  always_comb
    dram_rdata = (!dram_cas_n && !dram_ras_n && cas_cnt >= T_ACC - 1) ?
                 mem[{row_l, col_l}] : 16'hDEAD;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input int r, input int c, input int d,
                        output int n, output int rd);
    @(negedge clk);
    req = 1'b1; we = w; addr = {r[ROW_W-1:0], c[COL_W-1:0]}; wdata = d[DW-1:0];
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!ready && n < 80);
    rd = int'(rdata);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_cbr();
    int c0 = cbr_cnt;
    for (int k = 0; k < 3*REF_INT && cbr_cnt == c0; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [5:0]  row;
    logic [4:0]  col;
    logic [15:0] data;
    logic [1:0]  kind;   // 0 closed page, 1 hit, 2 miss
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 6'd1, 5'd3,  16'hA1A1, 2'd0},
    '{1'b1, 6'd1, 5'd4,  16'hB2B2, 2'd1},
    '{1'b0, 6'd1, 5'd3,  16'hA1A1, 2'd1},
    '{1'b1, 6'd2, 5'd0,  16'hC3C3, 2'd2},
    '{1'b0, 6'd1, 5'd4,  16'hB2B2, 2'd2},
    '{1'b0, 6'd1, 5'd4,  16'hB2B2, 2'd1},
    '{1'b0, 6'd2, 5'd0,  16'hC3C3, 2'd2},
    '{1'b1, 6'd2, 5'd31, 16'hD4D4, 2'd1},
    '{1'b0, 6'd2, 5'd31, 16'hD4D4, 2'd1}
  };

  initial begin
    int n, rd, rf0, cf0, ta, tb;
    // R11: reset state
    idle(3);
    chk("R11 ras_n in reset", int'(dram_ras_n), 1);
    chk("R11 cas_n in reset", int'(dram_cas_n), 1);
    chk("R11 we_n in reset", int'(dram_we_n), 1);
    chk("R11 ready in reset", int'(ready), 0);
    chk("R11 rdata in reset", int'(rdata), 0);
    rst = 1'b0;
    idle(2);

    foreach (VEC[i]) begin
      rf0 = ras_falls; cf0 = cas_falls;
      access(VEC[i].w, int'(VEC[i].row), int'(VEC[i].col), int'(VEC[i].data), n, rd);
      case (VEC[i].kind)
        2'd0: begin chk("R2 closed latency", n, LAT_CLOSED); chk("R2 row opened", ras_falls - rf0, 1); end
        2'd1: begin chk("R3 hit latency", n, LAT_HIT); chk("R3 no row strobe", ras_falls - rf0, 0); end
        default: begin chk("R4 miss latency", n, LAT_MISS); chk("R4 row reopened", ras_falls - rf0, 1); end
      endcase
      chk("R7 one column strobe", cas_falls - cf0, 1);
      chk("R1 row on bus", int'(row_l), int'(VEC[i].row));
      chk("R1 column on bus", int'(col_l), int'(VEC[i].col));
      if (VEC[i].w) chk("R6 write stored", int'(mem[{VEC[i].row, VEC[i].col}]), int'(VEC[i].data));
      else          chk("R5 read data", rd, int'(VEC[i].data));
    end

    // R10: refresh with an open page forces a reopen
    wait_cbr();
    idle(100);
    access(1'b1, 5, 2, 16'h5E5E, n, rd);
    chk("R10 closed before refresh", n, LAT_CLOSED);
    wait_cbr();
    idle(10);
    chk("R8 refresh row strobe width", last_run, T_REF);
    rf0 = ras_falls;
    access(1'b0, 5, 2, 0, n, rd);
    chk("R10 reopen latency", n, LAT_CLOSED);
    chk("R10 new row strobe", ras_falls - rf0, 1);
    chk("R10 read data", rd, 16'h5E5E);

    // R8: spacing between refreshes while idle with page closed
    wait_cbr(); ta = cbr_t;
    wait_cbr(); tb = cbr_t;
    chk("R8 refresh spacing", tb - ta, REF_INT);

    // R9: idle open page closes by itself
    idle(10);
    access(1'b1, 7, 1, 16'h7070, n, rd);
    chk("R9 open latency", n, LAT_CLOSED);
    for (int k = 0; k < 2*RAS_MAX && !dram_ras_n; k++) @(negedge clk);
    idle(2);
    chk("R9 page closed", int'(dram_ras_n), 1);
    chk("R9 open duration", last_run, RAS_MAX - T_CW);
    chk("R9 max row strobe", int'(max_run <= RAS_MAX), 1);

    // R11: reset with a page open
    access(1'b1, 8, 0, 16'h8181, n, rd);
    @(negedge clk); rst = 1'b1;
    idle(2);
    chk("R11 ras_n after reset", int'(dram_ras_n), 1);
    chk("R11 cas_n after reset", int'(dram_cas_n), 1);
    chk("R11 ready after reset", int'(ready), 0);
    chk("R11 rdata after reset", int'(rdata), 0);
    rst = 1'b0;
    idle(2);
    rf0 = ras_falls;
    access(1'b0, 8, 0, 0, n, rd);
    chk("R11 no page after reset", n, LAT_CLOSED);
    chk("R11 row reopened", ras_falls - rf0, 1);
    chk("R11 data kept", rd, 16'h8181);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule